// File: doc/BRIEF.md
# Deep Power-Down Wake Controller

This block holds one 16-bit control register and a small state machine that together manage a chip's deep power-down state. Software writes a 1 to the power-down bit of the register, and the controller enters the asleep state. While asleep it watches three asynchronous, active-low host bus strobes: chip enable, output enable and write enable. When the selected wake trigger occurs, it returns to the active state and issues a single-cycle wake pulse. The power-down status flag and the wake pulse are meant for the device's power and clock management logic. That logic is not part of this block.

The wake trigger is set by a select bit in the same register. With the select bit cleared, any new assertion of chip enable wakes the device. With it set, only a complete read strobe (chip enable with output enable) or a complete write strobe (chip enable with write enable) wakes the device. Each strobe passes through a parameterised flip-flop synchroniser. The wake condition is then edge-detected, so only an assertion that begins while the controller is asleep can wake it.

Top module: `dpd_wake_ctrl`

## Requirements
- R1: After a synchronous reset, `pd_active` and `wake_pulse` are 0 and the control register reads 0x0000.
- R2: The control register sits at address `CTRL_ADDR` (default 0x6). `reg_rdata` shows the register one cycle after `reg_addr` is presented. Bits 15:2 always read 0. Other addresses read 0x0000, and writes to them change nothing.
- R3: A write of a 1 to bit 0 (power-down) sets `pd_active` at the clock edge that takes the write. While asleep, bit 0 reads 1.
- R4: A write of a 0 to bit 0 has no effect. `pd_active` keeps its value whether the controller is active or asleep.
- R5: Bit 1 (wake select) is read/write, resets to 0, and is loaded from `reg_wdata[1]` on every write to `CTRL_ADDR`.
- R6: With wake select 0, driving `host_ce_n` low while asleep wakes the controller. `pd_active` falls at the third rising clock edge after the strobe changes (two synchroniser stages plus one state register).
- R7: With wake select 1, `host_ce_n` low alone does not wake the controller. Adding `host_oe_n` low does wake it, with the R6 latency.
- R8: With wake select 1, `host_ce_n` and `host_we_n` low together wake the controller, with the R6 latency.
- R9: On wake, `pd_active` clears and `wake_pulse` is high for exactly one cycle, in the same cycle. Afterwards bit 0 reads 0. `wake_pulse` is never high while the controller stays active.
- R10: Only a new qualifying assertion wakes the controller. A trigger condition already held when power-down is entered does not wake it until it is released and asserted again. Strobes while active produce no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | ADDR_W | Register port address |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Registered read data for `reg_addr` |
| host_ce_n | input | 1 | Host chip enable, active low, asynchronous |
| host_oe_n | input | 1 | Host output enable, active low, asynchronous |
| host_we_n | input | 1 | Host write enable, active low, asynchronous |
| pd_active | output | 1 | High while in deep power-down |
| wake_pulse | output | 1 | One-cycle pulse on the cycle the controller wakes |

## Verification
The bench drives chip enable on its own with wake select set and checks that the controller stays asleep. A design that treated any chip enable as a wake source would drop out of power-down early. It enters power-down while chip enable is already held low. A level-sensitive design would then wake at once instead of waiting for a fresh assertion. The bench also checks the exact wake cycle against the synchroniser depth and counts pulses, so a missing stage, a stretched pulse or a pulse while active all show up. A write of 0 to the power-down bit, made both while asleep and while active, shows whether that write wrongly clears or sets the state.

// File: rtl/dpd_wake_pkg.sv
package dpd_wake_pkg;
  localparam int REG_W      = 16;
  localparam int BIT_PD     = 0;
  localparam int BIT_WSEL   = 1;
  localparam int N_STROBES  = 3;
  localparam int IDX_CE     = 0;
  localparam int IDX_OE     = 1;
  localparam int IDX_WE     = 2;

  typedef enum logic {
    ST_ACTIVE = 1'b0,
    ST_ASLEEP = 1'b1
  } pd_state_t;
endpackage

// File: rtl/dpd_strobe_sync.sv
module dpd_strobe_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_n,
  output logic [WIDTH-1:0] asserted
);
  localparam int LAST = STAGES - 1;

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= '0;
      else     chain <= {chain[STAGES-2:0], ~async_n[b]};
    end
    assign asserted[b] = chain[LAST];
  end
endmodule

// File: rtl/dpd_wake_detect.sv
module dpd_wake_detect
  import dpd_wake_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic [N_STROBES-1:0] strobe_s,
  input  logic                 wake_sel,
  output logic                 trig
);
  logic qual, qual_q;

  always_comb begin
    if (wake_sel)
      qual = strobe_s[IDX_CE] & (strobe_s[IDX_OE] | strobe_s[IDX_WE]);
    else
      qual = strobe_s[IDX_CE];
  end

  always_ff @(posedge clk) begin
    if (rst) qual_q <= 1'b0;
    else     qual_q <= qual;
  end

  assign trig = qual & ~qual_q;

  p_sel1_needs_data_strobe_r7: assert property (@(posedge clk) disable iff (rst)
    (trig && wake_sel) |-> (strobe_s[IDX_OE] || strobe_s[IDX_WE]));
  p_trig_new_assertion_r10: assert property (@(posedge clk) disable iff (rst)
    trig |=> !trig);
endmodule

// File: rtl/dpd_ctrl_regs.sv
module dpd_ctrl_regs
  import dpd_wake_pkg::*;
#(
  parameter int             ADDR_W    = 4,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 4'h6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [REG_W-1:0]  reg_wdata,
  input  logic              pd_state,
  output logic              wake_sel,
  output logic              pd_set_req,
  output logic [REG_W-1:0]  reg_rdata
);
  logic hit;
  logic [REG_W-1:0] view;

  assign hit        = (reg_addr == CTRL_ADDR);
  assign pd_set_req = reg_wr & hit & reg_wdata[BIT_PD];

  always_ff @(posedge clk) begin
    if (rst)              wake_sel <= 1'b0;
    else if (reg_wr && hit) wake_sel <= reg_wdata[BIT_WSEL];
  end

  always_comb begin
    view           = '0;
    view[BIT_PD]   = pd_state;
    view[BIT_WSEL] = wake_sel;
  end

  always_ff @(posedge clk) begin
    if (rst)      reg_rdata <= '0;
    else if (hit) reg_rdata <= view;
    else          reg_rdata <= '0;
  end

  p_sel_holds_without_write_r5: assert property (@(posedge clk) disable iff (rst)
    !(reg_wr && hit) |=> $stable(wake_sel));
endmodule

// File: rtl/dpd_wake_fsm.sv
module dpd_wake_fsm
  import dpd_wake_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic pd_set_req,
  input  logic trig,
  output logic pd_active,
  output logic wake_pulse
);
  pd_state_t state;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_ACTIVE;
      wake_pulse <= 1'b0;
    end else begin
      wake_pulse <= 1'b0;
      case (state)
        ST_ACTIVE: if (pd_set_req) state <= ST_ASLEEP;
        ST_ASLEEP: if (trig && !pd_set_req) begin
          state      <= ST_ACTIVE;
          wake_pulse <= 1'b1;
        end
        default: state <= ST_ACTIVE;
      endcase
    end
  end

  assign pd_active = (state == ST_ASLEEP);

  p_enter_on_write_r3: assert property (@(posedge clk) disable iff (rst)
    pd_set_req |=> pd_active);
  p_stay_asleep_r4: assert property (@(posedge clk) disable iff (rst)
    (pd_active && !trig) |=> pd_active);
  p_pulse_one_cycle_r9: assert property (@(posedge clk) disable iff (rst)
    wake_pulse |=> !wake_pulse);
  p_pulse_only_on_exit_r9: assert property (@(posedge clk) disable iff (rst)
    wake_pulse |-> (!pd_active && $past(pd_active)));
endmodule

// File: rtl/dpd_wake_ctrl.sv
module dpd_wake_ctrl
  import dpd_wake_pkg::*;
#(
  parameter int                ADDR_W      = 4,
  parameter logic [ADDR_W-1:0] CTRL_ADDR   = 4'h6,
  parameter int                SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [15:0]       reg_wdata,
  output logic [15:0]       reg_rdata,
  input  logic              host_ce_n,
  input  logic              host_oe_n,
  input  logic              host_we_n,
  output logic              pd_active,
  output logic              wake_pulse
);
  logic [N_STROBES-1:0] strobes_n, strobes_s;
  logic wake_sel, pd_set_req, trig;

  always_comb begin
    strobes_n         = '1;
    strobes_n[IDX_CE] = host_ce_n;
    strobes_n[IDX_OE] = host_oe_n;
    strobes_n[IDX_WE] = host_we_n;
  end

  dpd_strobe_sync #(.WIDTH(N_STROBES), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst(rst), .async_n(strobes_n), .asserted(strobes_s));

  dpd_wake_detect detect_i (
    .clk(clk), .rst(rst), .strobe_s(strobes_s), .wake_sel(wake_sel), .trig(trig));

  dpd_ctrl_regs #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)) regs_i (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .pd_state(pd_active), .wake_sel(wake_sel),
    .pd_set_req(pd_set_req), .reg_rdata(reg_rdata));

  dpd_wake_fsm fsm_i (
    .clk(clk), .rst(rst), .pd_set_req(pd_set_req), .trig(trig),
    .pd_active(pd_active), .wake_pulse(wake_pulse));
endmodule

// File: tb/dpd_wake_ctrl_tb_top.sv
`timescale 1ns/1ps
module dpd_wake_ctrl_tb_top;
  localparam logic [3:0] CTRL = 4'h6;
  localparam logic [3:0] OTHER = 4'h3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [3:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic host_ce_n = 1'b1, host_oe_n = 1'b1, host_we_n = 1'b1;
  logic pd_active, wake_pulse;

  int n_tests = 0;
  int n_fail = 0;
  int pulse_cnt = 0;
  bit done = 0;

  always #4 clk = ~clk;

  dpd_wake_ctrl dut_i (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .host_ce_n(host_ce_n),
    .host_oe_n(host_oe_n), .host_we_n(host_we_n), .pd_active(pd_active),
    .wake_pulse(wake_pulse));

  always @(negedge clk) if (wake_pulse) pulse_cnt++;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic strobes(input logic ce, input logic oe, input logic we);
    @(negedge clk);
    host_ce_n = ce; host_oe_n = oe; host_we_n = we;
  endtask

  task automatic t_reset();
    logic [15:0] d;
    check(pd_active == 0, "R1 pd_active after reset", pd_active, 0);
    check(wake_pulse == 0, "R1 wake_pulse after reset", wake_pulse, 0);
    rd(CTRL, d);
    check(d == 16'h0000, "R1 register after reset", d, 16'h0000);
  endtask

  task automatic t_regs();
    logic [15:0] d;
    wr(CTRL, 16'hFFFE);
    rd(CTRL, d);
    check(d == 16'h0002, "R2 R5 reserved bits zero, select set", d, 16'h0002);
    wr(OTHER, 16'hFFFF);
    check(pd_active == 0, "R2 write elsewhere no power-down", pd_active, 0);
    rd(CTRL, d);
    check(d == 16'h0002, "R2 write elsewhere ignored", d, 16'h0002);
    rd(OTHER, d);
    check(d == 16'h0000, "R2 other address reads zero", d, 16'h0000);
    wr(CTRL, 16'h0000);
    rd(CTRL, d);
    check(d == 16'h0000, "R5 select cleared", d, 16'h0000);
  endtask

  task automatic t_mode0();
    logic [15:0] d;
    int p0;
    wr(CTRL, 16'h0001);
    check(pd_active == 1, "R3 enter power-down", pd_active, 1);
    rd(CTRL, d);
    check(d == 16'h0001, "R3 bit0 reads 1 asleep", d, 16'h0001);
    wr(CTRL, 16'h0000);
    wait_n(2);
    check(pd_active == 1, "R4 write 0 while asleep", pd_active, 1);
    p0 = pulse_cnt;
    strobes(1'b0, 1'b1, 1'b1);
    wait_n(2);
    check(pd_active == 1, "R6 not awake after two edges", pd_active, 1);
    wait_n(1);
    check(pd_active == 0, "R6 awake on third edge", pd_active, 0);
    check(wake_pulse == 1, "R9 pulse with wake", wake_pulse, 1);
    wait_n(1);
    check(wake_pulse == 0, "R9 pulse one cycle", wake_pulse, 0);
    rd(CTRL, d);
    check(d == 16'h0000, "R9 bit0 reads 0 after wake", d, 16'h0000);
    strobes(1'b1, 1'b1, 1'b1);
    wait_n(4);
    check(pulse_cnt - p0 == 1, "R9 single pulse", pulse_cnt - p0, 1);
  endtask

  task automatic t_mode1_read();
    int p0;
    wr(CTRL, 16'h0003);
    p0 = pulse_cnt;
    strobes(1'b0, 1'b1, 1'b1);
    wait_n(6);
    check(pd_active == 1, "R7 chip enable alone no wake", pd_active, 1);
    check(pulse_cnt == p0, "R7 no pulse on chip enable alone", pulse_cnt - p0, 0);
    strobes(1'b0, 1'b0, 1'b1);
    wait_n(2);
    check(pd_active == 1, "R7 read strobe latency", pd_active, 1);
    wait_n(1);
    check(pd_active == 0 && wake_pulse == 1, "R7 read strobe wakes",
          {pd_active, wake_pulse}, 2'b01);
    strobes(1'b1, 1'b1, 1'b1);
    wait_n(4);
  endtask

  task automatic t_mode1_write();
    wr(CTRL, 16'h0003);
    strobes(1'b0, 1'b1, 1'b0);
    wait_n(2);
    check(pd_active == 1, "R8 write strobe latency", pd_active, 1);
    wait_n(1);
    check(pd_active == 0 && wake_pulse == 1, "R8 write strobe wakes",
          {pd_active, wake_pulse}, 2'b01);
    strobes(1'b1, 1'b1, 1'b1);
    wait_n(4);
  endtask

  task automatic t_held();
    wr(CTRL, 16'h0000);
    strobes(1'b0, 1'b1, 1'b1);
    wait_n(4);
    wr(CTRL, 16'h0001);
    wait_n(6);
    check(pd_active == 1, "R10 held chip enable no wake", pd_active, 1);
    strobes(1'b1, 1'b1, 1'b1);
    wait_n(4);
    check(pd_active == 1, "R10 release no wake", pd_active, 1);
    strobes(1'b0, 1'b1, 1'b1);
    wait_n(3);
    check(pd_active == 0, "R10 fresh assertion wakes", pd_active, 0);
    strobes(1'b1, 1'b1, 1'b1);
    wait_n(4);
  endtask

  task automatic t_active();
    int p0;
    p0 = pulse_cnt;
    for (int i = 0; i < 3; i++) begin
      strobes(1'b0, 1'b0, 1'b1);
      wait_n(3);
      strobes(1'b1, 1'b1, 1'b1);
      wait_n(3);
    end
    check(pulse_cnt == p0, "R10 no pulse while active", pulse_cnt - p0, 0);
    wr(CTRL, 16'h0000);
    wait_n(2);
    check(pd_active == 0, "R4 write 0 while active", pd_active, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_regs();
    t_mode0();
    t_mode1_read();
    t_mode1_write();
    t_held();
    t_active();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      done = 1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run hung, actual 1 expected 0");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule